// File: doc/BRIEF.md
# Local Countdown Timer with Interrupt Entry

The block is a per-core countdown timer. Software programs a divide setting, a starting count and a timer entry. Writing the starting count loads the counter and restarts the clock prescaler. The counter then steps down once per divided clock period. When it reaches zero the block looks at the timer entry. If the entry is unmasked, the block raises exactly one of four one-cycle requests. A fixed request carries an 8-bit vector. The other three are special lines: system-management, non-maskable and external.

The divide setting uses a 3-bit code whose bits are not adjacent in the written word. The code maps to a shift amount that wraps, so one code selects divide-by-one. The entry can select periodic operation, in which the counter reloads the starting count at every expiry. The current count, the starting count and the stored divide setting can all be read at any time.

Top module: `local_countdown_timer`

## Requirements
- R1: A divide-setting write (select 0) stores only bits 0, 1 and 3 of the data; `divCfg` reads back the data ANDed with 0xB.
- R2: The divide code is {bit 3, bit 1, bit 0}. The shift is (code + 1) mod 8 and the divider is 2 to the power of the shift, so code 7 divides by 1 and code 6 divides by 128.
- R3: A starting-count write (select 1) loads `curCount` and `initCount` with the data on the next edge and restarts the prescaler. The first decrement comes one divider period after the write.
- R4: With starting count N and divider D, the expiry request appears N·D cycles after the write. In one-shot mode (entry bit 17 clear) `curCount` then stays at 0 and nothing further is requested.
- R5: With entry bit 17 set, the counter reloads N on each expiry. Requests then repeat every N·D cycles.
- R6: A starting count of zero stops the timer. `curCount` stays 0 and no request is ever raised.
- R7: When entry bit 16 (mask) is set at expiry, no request of any kind is raised.
- R8: Delivery code 0 in entry bits 10:8 raises `vecReq` for one cycle, with `vecNum` equal to entry bits 7:0.
- R9: Delivery codes 2, 4 and 7 raise `smiReq`, `nmiReq` and `extReq` respectively, for one cycle. The other codes (1, 3, 5, 6) raise nothing. At most one request line is high at a time.
- R10: An entry write (select 2) takes effect for the next expiry without disturbing the running count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 2 | Write target: 0 divide, 1 starting count, 2 timer entry, 3 ignored |
| wrData | input | 32 | Write data |
| curCount | output | CNT_W | Present counter value |
| initCount | output | CNT_W | Stored starting count |
| divCfg | output | 4 | Stored divide setting |
| vecReq | output | 1 | Fixed-vector request pulse |
| vecNum | output | 8 | Vector for the fixed request |
| smiReq | output | 1 | System-management request pulse |
| nmiReq | output | 1 | Non-maskable request pulse |
| extReq | output | 1 | External request pulse |

## Verification
The bench builds the block with CNT_W = 8. This keeps a full sweep of all eight divide codes, against several starting counts, short enough to run. The slowest case, divide-by-128 with count 5, still expires in a few hundred cycles. Each case measures the cycle of expiry and the count after the first divided period, and compares both with N·D computed in the bench. With the small counter, all eight delivery codes, masking, zero count, periodic reload and a mid-count entry change can also be swept exhaustively.

// File: rtl/ltmr_pkg.sv
package ltmr_pkg;
  localparam int PRE_W = 7;

  localparam logic [1:0] SEL_DIV   = 2'd0;
  localparam logic [1:0] SEL_INIT  = 2'd1;
  localparam logic [1:0] SEL_ENTRY = 2'd2;

  localparam logic [2:0] DLV_FIXED = 3'd0;
  localparam logic [2:0] DLV_SMI   = 3'd2;
  localparam logic [2:0] DLV_NMI   = 3'd4;
  localparam logic [2:0] DLV_EXT   = 3'd7;

  typedef struct packed {
    logic loadDiv;
    logic loadInit;
    logic loadEntry;
    logic dec;
    logic reload;
    logic halt;
  } tmrStrobe_t;
endpackage

// File: rtl/ltmr_datapath.sv
module ltmr_datapath
  import ltmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  tmrStrobe_t       strobe,
  input  logic [31:0]      wrData,
  output logic             running,
  output logic             tick,
  output logic             countIsOne,
  output logic             entryPeriodic,
  output logic             entryMask,
  output logic [2:0]       entryMode,
  output logic [7:0]       entryVec,
  output logic [CNT_W-1:0] curCount,
  output logic [CNT_W-1:0] initCount,
  output logic [3:0]       divCfg
);
  localparam int ENTRY_W = 18;

  logic [PRE_W-1:0]   preCnt;
  logic [ENTRY_W-1:0] entryReg;
  logic [2:0]         divCode;
  logic [2:0]         shiftAmt;
  logic [PRE_W:0]     preMaskWide;
  logic [PRE_W-1:0]   preMask;

  assign divCode     = {divCfg[3], divCfg[1:0]};
  assign shiftAmt    = divCode + 3'd1;
  assign preMaskWide = ({{PRE_W{1'b0}}, 1'b1} << shiftAmt) - 1'b1;
  assign preMask     = preMaskWide[PRE_W-1:0];
  assign tick        = (preCnt & preMask) == preMask;
  assign countIsOne  = curCount == CNT_W'(1);

  assign entryVec      = entryReg[7:0];
  assign entryMode     = entryReg[10:8];
  assign entryMask     = entryReg[16];
  assign entryPeriodic = entryReg[17];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      preCnt   <= '0;
      divCfg   <= '0;
      entryReg <= ENTRY_W'(1) << 16;
    end else begin
      preCnt <= strobe.loadInit ? '0 : preCnt + 1'b1;
      if (strobe.loadDiv)   divCfg   <= wrData[3:0] & 4'hB;
      if (strobe.loadEntry) entryReg <= wrData[ENTRY_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      curCount  <= '0;
      initCount <= '0;
      running   <= 1'b0;
    end else if (strobe.loadInit) begin
      curCount  <= wrData[CNT_W-1:0];
      initCount <= wrData[CNT_W-1:0];
      running   <= wrData[CNT_W-1:0] != '0;
    end else if (strobe.reload) begin
      curCount <= initCount;
    end else if (strobe.halt) begin
      curCount <= '0;
      running  <= 1'b0;
    end else if (strobe.dec) begin
      curCount <= curCount - 1'b1;
    end
  end

  a_r3_load_takes_value: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.loadInit |=> curCount == $past(wrData[CNT_W-1:0]));
  a_r1_div_bits_kept: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.loadDiv |=> divCfg == ($past(wrData[3:0]) & 4'hB));
  a_r6_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !strobe.loadInit) |=> $stable(curCount));
  a_r4_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !strobe.loadInit && !strobe.reload)
      |=> (curCount == $past(curCount) || curCount == $past(curCount) - 1'b1));
endmodule

// File: rtl/ltmr_ctrl.sv
module ltmr_ctrl
  import ltmr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wrEn,
  input  logic [1:0] wrSel,
  input  logic       running,
  input  logic       tick,
  input  logic       countIsOne,
  input  logic       entryPeriodic,
  input  logic       entryMask,
  input  logic [2:0] entryMode,
  input  logic [7:0] entryVec,
  output tmrStrobe_t strobe,
  output logic       vecReq,
  output logic [7:0] vecNum,
  output logic       smiReq,
  output logic       nmiReq,
  output logic       extReq
);
  logic expire;

  always_comb begin
    strobe.loadDiv   = wrEn && wrSel == SEL_DIV;
    strobe.loadInit  = wrEn && wrSel == SEL_INIT;
    strobe.loadEntry = wrEn && wrSel == SEL_ENTRY;
    strobe.dec       = running && tick && !strobe.loadInit;
    expire           = strobe.dec && countIsOne;
    strobe.reload    = expire && entryPeriodic;
    strobe.halt      = expire && !entryPeriodic;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vecReq <= 1'b0;
      vecNum <= '0;
      smiReq <= 1'b0;
      nmiReq <= 1'b0;
      extReq <= 1'b0;
    end else begin
      vecReq <= 1'b0;
      smiReq <= 1'b0;
      nmiReq <= 1'b0;
      extReq <= 1'b0;
      if (expire && !entryMask) begin
        case (entryMode)
          DLV_FIXED: begin
            vecReq <= 1'b1;
            vecNum <= entryVec;
          end
          DLV_SMI: smiReq <= 1'b1;
          DLV_NMI: nmiReq <= 1'b1;
          DLV_EXT: extReq <= 1'b1;
          default: ;
        endcase
      end
    end
  end

  a_r9_one_line: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({vecReq, smiReq, nmiReq, extReq}));
  a_r7_masked_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && entryMask) |=> !(vecReq || smiReq || nmiReq || extReq));
  a_r8_req_after_expiry: assert property (@(posedge clk) disable iff (!rst_n)
    (vecReq || smiReq || nmiReq || extReq) |-> $past(expire));
  a_r6_no_expiry_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> !expire);
endmodule

// File: rtl/local_countdown_timer.sv
module local_countdown_timer
  import ltmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wrEn,
  input  logic [1:0]       wrSel,
  input  logic [31:0]      wrData,
  output logic [CNT_W-1:0] curCount,
  output logic [CNT_W-1:0] initCount,
  output logic [3:0]       divCfg,
  output logic             vecReq,
  output logic [7:0]       vecNum,
  output logic             smiReq,
  output logic             nmiReq,
  output logic             extReq
);
  tmrStrobe_t strobe;
  logic       running, tick, countIsOne;
  logic       entryPeriodic, entryMask;
  logic [2:0] entryMode;
  logic [7:0] entryVec;

  ltmr_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrSel(wrSel),
    .running(running), .tick(tick), .countIsOne(countIsOne),
    .entryPeriodic(entryPeriodic), .entryMask(entryMask),
    .entryMode(entryMode), .entryVec(entryVec), .strobe(strobe),
    .vecReq(vecReq), .vecNum(vecNum), .smiReq(smiReq),
    .nmiReq(nmiReq), .extReq(extReq)
  );

  ltmr_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .wrData(wrData),
    .running(running), .tick(tick), .countIsOne(countIsOne),
    .entryPeriodic(entryPeriodic), .entryMask(entryMask),
    .entryMode(entryMode), .entryVec(entryVec),
    .curCount(curCount), .initCount(initCount), .divCfg(divCfg)
  );
endmodule

// File: tb/local_countdown_timer_test.sv
`timescale 1ns/1ps
module local_countdown_timer_test;
  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wrEn = 1'b0;
  logic [1:0] wrSel = '0;
  logic [31:0] wrData = '0;
  logic [CNT_W-1:0] curCount, initCount;
  logic [3:0] divCfg;
  logic vecReq, smiReq, nmiReq, extReq;
  logic [7:0] vecNum;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  local_countdown_timer #(.CNT_W(CNT_W)) uut (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .curCount(curCount), .initCount(initCount), .divCfg(divCfg),
    .vecReq(vecReq), .vecNum(vecNum), .smiReq(smiReq), .nmiReq(nmiReq),
    .extReq(extReq)
  );

  task automatic check(input string req, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] data);
    @(negedge clk);
    wrEn = 1'b1; wrSel = sel; wrData = data;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  function automatic int divOf(input int code);
    return 1 << ((code + 1) % 8);
  endfunction

  function automatic logic [31:0] divWord(input int code);
    return {28'd0, code[2], 1'b0, code[1:0]};
  endfunction

  initial begin
    #(200000 * 10);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int firstHit, pulses, hits;
    int lastHit;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R6 reset count", curCount, 0);
    check("R1 reset div", divCfg, 0);
    check("R9 reset lines", {vecReq, smiReq, nmiReq, extReq}, 0);

    // R1: only bits 0,1,3 kept
    wr(2'd0, 32'hFFFF_FFFF);
    check("R1 all ones", divCfg, 4'hB);
    wr(2'd0, 32'h0000_0004);
    check("R1 bit2 dropped", divCfg, 0);

    // R2/R3/R4 sweep: every divide code, several counts, fixed vector
    wr(2'd2, 32'h0000_0042);
    for (int code = 0; code < 8; code++) begin
      for (int ni = 0; ni < 4; ni++) begin
        automatic int n = (ni == 3) ? 5 : ni + 1;
        automatic int d = divOf(code);
        wr(2'd0, divWord(code));
        wr(2'd1, n);
        check("R3 initCount", initCount, n);
        firstHit = -1;
        for (int k = 1; k <= n * d + 4; k++) begin
          @(negedge clk);
          if (k == d && n > 1) check("R3 first step", curCount, n - 1);
          if (vecReq && firstHit < 0) firstHit = k;
        end
        check("R2 R4 expiry cycle", firstHit, n * d);
        check("R4 stays zero", curCount, 0);
      end
    end

    // R4: one-shot never fires again
    pulses = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (vecReq) pulses++;
    end
    check("R4 no refire", pulses, 0);

    // R5: periodic, D=2 (code 0), N=3
    wr(2'd0, divWord(0));
    wr(2'd2, 32'h0002_0051);
    wr(2'd1, 3);
    hits = 0; lastHit = 0; pulses = 0;
    for (int k = 1; k <= 19; k++) begin
      @(negedge clk);
      if (vecReq) begin
        hits++;
        check("R5 period", k - lastHit, 6);
        check("R5 reloaded", curCount, 3);
        check("R8 vector", vecNum, 8'h51);
        lastHit = k;
      end
    end
    check("R5 repeat count", hits, 3);

    // R10: switch to one-shot mid count, takes effect at next expiry
    wr(2'd2, 32'h0000_0051);
    hits = 0;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (vecReq) hits++;
    end
    check("R10 final one-shot", hits, 1);
    check("R10 stopped", curCount, 0);

    // R6: zero count
    wr(2'd0, divWord(7));
    wr(2'd2, 32'h0002_0010);
    wr(2'd1, 0);
    pulses = 0;
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      if (vecReq | smiReq | nmiReq | extReq) pulses++;
    end
    check("R6 no request", pulses, 0);
    check("R6 count zero", curCount, 0);

    // R7: mask suppresses every delivery code
    for (int m = 0; m < 8; m++) begin
      wr(2'd2, 32'h0001_0000 | (m << 8) | 32'h33);
      wr(2'd1, 2);
      pulses = 0;
      for (int k = 0; k < 6; k++) begin
        @(negedge clk);
        if (vecReq | smiReq | nmiReq | extReq) pulses++;
      end
      check("R7 masked", pulses, 0);
      check("R7 still expired", curCount, 0);
    end

    // R8/R9: every delivery code, D=1, N=2
    for (int m = 0; m < 8; m++) begin
      automatic int vc = 0, sc = 0, nc = 0, ec = 0, multi = 0;
      wr(2'd2, (m << 8) | 32'hA5);
      wr(2'd1, 2);
      for (int k = 1; k <= 6; k++) begin
        @(negedge clk);
        if (vecReq) begin vc++; check("R8 vecNum", vecNum, 8'hA5); end
        if (smiReq) sc++;
        if (nmiReq) nc++;
        if (extReq) ec++;
        if ((vecReq + smiReq + nmiReq + extReq) > 1) multi++;
      end
      check("R8 fixed pulse", vc, (m == 0) ? 1 : 0);
      check("R9 smi pulse", sc, (m == 2) ? 1 : 0);
      check("R9 nmi pulse", nc, (m == 4) ? 1 : 0);
      check("R9 ext pulse", ec, (m == 7) ? 1 : 0);
      check("R9 exclusive", multi, 0);
    end

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule